// File: doc/BRIEF.md
# Packet Disposition and Truncation Controller

This block sits behind a packet header decoder and a byte-lane receiver. For each received packet it decides, from the header verdict and the start-of-transmission status, whether the packet is forwarded downstream or dropped. Dropping a packet discards all of its bytes until the end-of-transmission marker. Three errors kill a packet: a double-bit header ECC error, a start-of-transmission synchronisation failure and an unknown data type. Soft conditions only raise a pulse and the packet continues. The soft conditions are a corrected single-bit header error, a plain start-of-transmission error and a CRC mismatch.

For long packets the controller counts payload bytes against the header word count on a four-lane byte stream. It forwards only the bytes that belong to the payload. Unused lanes on the final beat are zeroed. When the transmission ends before the word count is reached, the controller closes the packet at the bytes actually received and raises a truncation pulse. Short packets carry no payload and no CRC, so they are forwarded as soon as the header is accepted.

The FSM has four states:
- `ST_IDLE` waits for a header.
- `ST_BODY` counts payload.
- `ST_CRC` waits for the CRC verdict.
- `ST_DRAIN` discards bytes until end of transmission.

The transitions are:
- **accept-long**: `ST_IDLE` to `ST_BODY`.
- **accept-empty**: `ST_IDLE` to `ST_CRC`, for a long packet with a word count of zero.
- **accept-short/kill**: `ST_IDLE` to `ST_DRAIN`. The controller goes straight back to `ST_IDLE` if end of transmission comes with the header.
- **count-done**: `ST_BODY` to `ST_CRC`.
- **truncate**: `ST_BODY` to `ST_IDLE`.
- **crc-seen**: `ST_CRC` to `ST_DRAIN`, or to `ST_IDLE` if end of transmission has already been seen.
- **drained**: `ST_DRAIN` to `ST_IDLE`.

Top module: `pkt_gate`

## Requirements
- R1: While reset is held, and in the first cycle after it, every output is 0, and the controller accepts a header in the first cycle after release.
- R2: A header with `hdr_ecc_dbl` set (and no sync failure) gives one-cycle pulses on `pkt_drop` and `err_ecc_dbl`. `err_dtype` is suppressed. No byte of the packet appears on `out_vld` until `rx_eot`.
- R3: A header with `hdr_sync_err` set gives pulses on `pkt_drop` and `err_sync` only. `err_ecc_dbl`, `err_dtype`, `err_ecc_fix` and `err_sot` all stay 0. The packet's bytes are discarded until `rx_eot`.
- R4: A data type at or above 0x10 whose bit (type minus 0x10) is clear in `LONG_OK` is unknown. Unless a sync or double ECC error takes precedence, such a header gives pulses on `pkt_drop` and `err_dtype`. The default `LONG_OK` accepts types 0x12, 0x18 to 0x1F, 0x20 to 0x24 and 0x28 to 0x2D.
- R5: `hdr_ecc_fix` on a header without a kill error pulses `err_ecc_fix`, and the packet is forwarded (`pkt_fwd`).
- R6: `hdr_sot_err` without a sync failure pulses `err_sot`, and the packet is still forwarded unless another kill error applies.
- R7: In `ST_CRC`, a `crc_vld` with `crc_bad` pulses `err_crc` without any `pkt_drop`. A `crc_vld` with `crc_bad` at 0 gives no pulse.
- R8: In `ST_BODY`, each `rx_vld` beat is forwarded one cycle later with `out_nb` equal to the smaller of `rx_nb` and the bytes still owed. Lane k (bits 8k+7:8k) is zeroed for k ≥ `out_nb`. `out_last` marks the beat that completes the word count, and later bytes are not forwarded.
- R9: If `rx_eot` arrives in `ST_BODY` before the word count is met, the bytes of that beat are forwarded with `out_last`. `err_wc_trunc` pulses and the controller returns to `ST_IDLE`. An end marker on the beat that exactly completes the count is not a truncation.
- R10: A data type below 0x10 is a short packet. It is forwarded at the header with no payload output and no CRC wait, so a following `crc_vld` raises no `err_crc`.
- R11: `hdr_vld` outside `ST_IDLE` is ignored and produces no `pkt_fwd`, `pkt_drop` or header error pulse.
- R12: Every output is registered. A verdict, beat or CRC result is visible in the cycle after the input cycle that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_vld | input | 1 | Header strobe |
| hdr_dtype | input | 6 | Header data type |
| hdr_wc | input | 16 | Header word count in bytes |
| hdr_ecc_dbl | input | 1 | Uncorrectable header ECC error |
| hdr_ecc_fix | input | 1 | Corrected single-bit header error |
| hdr_sot_err | input | 1 | Soft start-of-transmission error |
| hdr_sync_err | input | 1 | Start-of-transmission sync failure |
| rx_vld | input | 1 | Byte beat valid |
| rx_data | input | 32 | Byte beat, lane 0 in bits 7:0 |
| rx_nb | input | 3 | Valid bytes in the beat, 1 to 4 |
| rx_eot | input | 1 | End of transmission marker |
| crc_vld | input | 1 | CRC verdict strobe |
| crc_bad | input | 1 | CRC mismatch |
| out_vld | output | 1 | Forwarded beat valid |
| out_data | output | 32 | Forwarded beat, unused lanes zeroed |
| out_nb | output | 3 | Bytes in the forwarded beat |
| out_last | output | 1 | Final forwarded beat of the packet |
| pkt_fwd | output | 1 | Packet accepted pulse |
| pkt_drop | output | 1 | Packet dropped pulse |
| err_sync | output | 1 | Sync failure pulse |
| err_ecc_dbl | output | 1 | Double ECC error pulse |
| err_dtype | output | 1 | Unknown data type pulse |
| err_ecc_fix | output | 1 | Corrected header error pulse |
| err_sot | output | 1 | Soft start error pulse |
| err_crc | output | 1 | CRC mismatch pulse |
| err_wc_trunc | output | 1 | Word count truncation pulse |

## Verification
The completion of the word count and the end-of-transmission marker can land on the same beat. The bench provokes both versions of this coincidence.
- In the first, the marker comes with the beat that exactly fills the word count. The bench expects `out_last` without `err_wc_trunc`. Since end of transmission has then already been seen, the CRC verdict must return the controller to idle, and a new header is accepted at once.
- In the second, the marker comes on a beat that is still short of the count. The bench expects both `out_last` and `err_wc_trunc`, with `out_nb` equal to the bytes actually delivered.

// File: rtl/pkt_gate_pkg.sv
package pkt_gate_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BODY  = 2'd1,
        ST_CRC   = 2'd2,
        ST_DRAIN = 2'd3
    } gate_st_e;

    typedef struct packed {
        logic kill;
        logic short_pkt;
        logic zero_len;
        logic e_sync;
        logic e_dbl;
        logic e_dtype;
        logic e_fix;
        logic e_sot;
    } hdr_verdict_t;

endpackage

// File: rtl/pkt_gate_hdr.sv
module pkt_gate_hdr
    import pkt_gate_pkg::*;
#(
    parameter int DTW       = 6,
    parameter int WCW       = 16,
    parameter int SHORT_LIM = 16,
    parameter logic [(1<<DTW)-SHORT_LIM-1:0] LONG_OK = '0
) (
    input  logic [DTW-1:0] dtype,
    input  logic [WCW-1:0] wc,
    input  logic           ecc_dbl,
    input  logic           ecc_fix,
    input  logic           sot_err,
    input  logic           sync_err,
    output hdr_verdict_t   verdict
);
    localparam int LONG_N = (1 << DTW) - SHORT_LIM;

    logic           is_short;
    logic [DTW-1:0] long_idx;
    logic           known;

    always_comb begin
        is_short = (dtype < DTW'(SHORT_LIM));
        long_idx = dtype - DTW'(SHORT_LIM);
        known    = 1'b1;
        if (!is_short) begin
            known = 1'b0;
            for (int i = 0; i < LONG_N; i++) begin
                if (long_idx == DTW'(i)) begin
                    known = LONG_OK[i];
                end
            end
        end
    end

    // precedence: sync failure hides all header flags, double ECC hides type
    always_comb begin
        verdict.e_sync    = sync_err;
        verdict.e_dbl     = ecc_dbl & ~sync_err;
        verdict.e_dtype   = ~known & ~ecc_dbl & ~sync_err;
        verdict.e_fix     = ecc_fix & ~ecc_dbl & ~sync_err;
        verdict.e_sot     = sot_err & ~sync_err;
        verdict.kill      = sync_err | ecc_dbl | ~known;
        verdict.short_pkt = is_short;
        verdict.zero_len  = (wc == '0);
    end

endmodule

// File: rtl/pkt_gate_cnt.sv
module pkt_gate_cnt #(
    parameter int WCW = 16,
    parameter int NBW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [WCW-1:0] load_wc,
    input  logic           dec,
    input  logic [NBW-1:0] beat_nb,
    output logic [NBW-1:0] take_nb,
    output logic           at_end
);
    logic [WCW-1:0] remain_q;
    logic [WCW-1:0] nb_ext;

    always_comb begin
        nb_ext  = WCW'(beat_nb);
        at_end  = (nb_ext >= remain_q);
        take_nb = at_end ? remain_q[NBW-1:0] : beat_nb;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_wc;
        end else if (dec) begin
            remain_q <= remain_q - WCW'(take_nb);
        end
    end

endmodule

// File: rtl/pkt_gate.sv
module pkt_gate
    import pkt_gate_pkg::*;
#(
    parameter int DTW       = 6,
    parameter int WCW       = 16,
    parameter int LANES     = 4,
    parameter int SHORT_LIM = 16,
    parameter logic [(1<<DTW)-SHORT_LIM-1:0] LONG_OK = 48'h0000_3F1F_FF04
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hdr_vld,
    input  logic [DTW-1:0]         hdr_dtype,
    input  logic [WCW-1:0]         hdr_wc,
    input  logic                   hdr_ecc_dbl,
    input  logic                   hdr_ecc_fix,
    input  logic                   hdr_sot_err,
    input  logic                   hdr_sync_err,
    input  logic                   rx_vld,
    input  logic [8*LANES-1:0]     rx_data,
    input  logic [$clog2(LANES+1)-1:0] rx_nb,
    input  logic                   rx_eot,
    input  logic                   crc_vld,
    input  logic                   crc_bad,
    output logic                   out_vld,
    output logic [8*LANES-1:0]     out_data,
    output logic [$clog2(LANES+1)-1:0] out_nb,
    output logic                   out_last,
    output logic                   pkt_fwd,
    output logic                   pkt_drop,
    output logic                   err_sync,
    output logic                   err_ecc_dbl,
    output logic                   err_dtype,
    output logic                   err_ecc_fix,
    output logic                   err_sot,
    output logic                   err_crc,
    output logic                   err_wc_trunc
);
    localparam int NBW = $clog2(LANES + 1);
    localparam int DW  = 8 * LANES;

    gate_st_e     st_q, st_d;
    logic         eot_seen_q, eot_seen_d;
    hdr_verdict_t verdict;
    logic [NBW-1:0] take_nb;
    logic           at_end;
    logic           cnt_load, cnt_dec;
    logic [DW-1:0]  masked;

    pkt_gate_hdr #(
        .DTW(DTW), .WCW(WCW), .SHORT_LIM(SHORT_LIM), .LONG_OK(LONG_OK)
    ) u_hdr (
        .dtype   (hdr_dtype),
        .wc      (hdr_wc),
        .ecc_dbl (hdr_ecc_dbl),
        .ecc_fix (hdr_ecc_fix),
        .sot_err (hdr_sot_err),
        .sync_err(hdr_sync_err),
        .verdict (verdict)
    );

    assign cnt_load = (st_q == ST_IDLE) && hdr_vld;
    assign cnt_dec  = (st_q == ST_BODY) && rx_vld;

    pkt_gate_cnt #(.WCW(WCW), .NBW(NBW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cnt_load),
        .load_wc(hdr_wc),
        .dec    (cnt_dec),
        .beat_nb(rx_nb),
        .take_nb(take_nb),
        .at_end (at_end)
    );

    // zero every lane beyond the bytes that belong to the payload
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign masked[8*g +: 8] = (NBW'(g) < take_nb) ? rx_data[8*g +: 8] : 8'h00;
    end

    always_comb begin
        st_d       = st_q;
        eot_seen_d = eot_seen_q;
        unique case (st_q)
            ST_IDLE: begin
                eot_seen_d = 1'b0;
                if (hdr_vld) begin
                    if (verdict.kill || verdict.short_pkt) begin
                        st_d = rx_eot ? ST_IDLE : ST_DRAIN;
                    end else if (verdict.zero_len) begin
                        st_d       = ST_CRC;
                        eot_seen_d = rx_eot;
                    end else begin
                        st_d = ST_BODY;
                    end
                end
            end
            ST_BODY: begin
                if (rx_vld && at_end) begin
                    st_d       = ST_CRC;
                    eot_seen_d = rx_eot;
                end else if (rx_eot) begin
                    st_d = ST_IDLE;
                end
            end
            ST_CRC: begin
                if (crc_vld) begin
                    st_d = (eot_seen_q || rx_eot) ? ST_IDLE : ST_DRAIN;
                end else if (rx_eot) begin
                    eot_seen_d = 1'b1;
                end
            end
            ST_DRAIN: begin
                if (rx_eot) begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            eot_seen_q <= 1'b0;
        end else begin
            st_q       <= st_d;
            eot_seen_q <= eot_seen_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld      <= 1'b0;
            out_data     <= '0;
            out_nb       <= '0;
            out_last     <= 1'b0;
            pkt_fwd      <= 1'b0;
            pkt_drop     <= 1'b0;
            err_sync     <= 1'b0;
            err_ecc_dbl  <= 1'b0;
            err_dtype    <= 1'b0;
            err_ecc_fix  <= 1'b0;
            err_sot      <= 1'b0;
            err_crc      <= 1'b0;
            err_wc_trunc <= 1'b0;
        end else begin
            out_vld      <= 1'b0;
            out_data     <= '0;
            out_nb       <= '0;
            out_last     <= 1'b0;
            pkt_fwd      <= 1'b0;
            pkt_drop     <= 1'b0;
            err_sync     <= 1'b0;
            err_ecc_dbl  <= 1'b0;
            err_dtype    <= 1'b0;
            err_ecc_fix  <= 1'b0;
            err_sot      <= 1'b0;
            err_crc      <= 1'b0;
            err_wc_trunc <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (hdr_vld) begin
                        pkt_fwd     <= ~verdict.kill;
                        pkt_drop    <= verdict.kill;
                        err_sync    <= verdict.e_sync;
                        err_ecc_dbl <= verdict.e_dbl;
                        err_dtype   <= verdict.e_dtype;
                        err_ecc_fix <= verdict.e_fix;
                        err_sot     <= verdict.e_sot;
                    end
                end
                ST_BODY: begin
                    if (rx_vld && (take_nb != '0)) begin
                        out_vld  <= 1'b1;
                        out_data <= masked;
                        out_nb   <= take_nb;
                    end
                    if (rx_vld && at_end) begin
                        out_last <= 1'b1;
                    end else if (rx_eot) begin
                        out_last     <= rx_vld && (take_nb != '0);
                        err_wc_trunc <= 1'b1;
                    end
                end
                ST_CRC: begin
                    if (crc_vld) begin
                        err_crc <= crc_bad;
                    end
                end
                ST_DRAIN: begin
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/pkt_gate_chk.sv
module pkt_gate_chk #(
    parameter int LANES = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       hdr_vld,
    input logic                       out_vld,
    input logic [$clog2(LANES+1)-1:0] out_nb,
    input logic                       out_last,
    input logic                       pkt_fwd,
    input logic                       pkt_drop,
    input logic                       err_sync,
    input logic                       err_ecc_dbl,
    input logic                       err_dtype,
    input logic                       err_ecc_fix,
    input logic                       err_sot,
    input logic                       err_wc_trunc
);
    p_fwd_drop_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_fwd && pkt_drop));

    p_drop_no_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_drop |=> !out_vld);

    p_dbl_hides_type_r2: assert property (@(posedge clk) disable iff (!rst_n)
        err_ecc_dbl |-> !err_dtype);

    p_sync_alone_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err_sync |-> (pkt_drop && !err_ecc_dbl && !err_dtype && !err_ecc_fix && !err_sot));

    p_type_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_dtype |-> pkt_drop);

    p_nb_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (out_nb != '0 && out_nb <= ($clog2(LANES+1))'(LANES)));

    p_last_is_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_vld);

    p_trunc_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_wc_trunc |=> !err_wc_trunc);

    p_verdict_from_hdr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_fwd || pkt_drop) |-> $past(hdr_vld));

endmodule

bind pkt_gate pkt_gate_chk #(.LANES(LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hdr_vld     (hdr_vld),
    .out_vld     (out_vld),
    .out_nb      (out_nb),
    .out_last    (out_last),
    .pkt_fwd     (pkt_fwd),
    .pkt_drop    (pkt_drop),
    .err_sync    (err_sync),
    .err_ecc_dbl (err_ecc_dbl),
    .err_dtype   (err_dtype),
    .err_ecc_fix (err_ecc_fix),
    .err_sot     (err_sot),
    .err_wc_trunc(err_wc_trunc)
);

// File: tb/pkt_gate_test.sv
module pkt_gate_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 14;

    // {dtype[6], dbl, fix, sot, sync, exp_fwd, exp_drop, e_sync, e_dbl, e_dtype, e_fix, e_sot}
    localparam logic [16:0] VEC [NV] = '{
        {6'h2A, 4'b0000, 2'b10, 5'b00000},
        {6'h2A, 4'b1000, 2'b01, 5'b01000},
        {6'h30, 4'b1000, 2'b01, 5'b01000},
        {6'h2A, 4'b0001, 2'b01, 5'b10000},
        {6'h30, 4'b1111, 2'b01, 5'b10000},
        {6'h30, 4'b0000, 2'b01, 5'b00100},
        {6'h13, 4'b0000, 2'b01, 5'b00100},
        {6'h1E, 4'b0100, 2'b10, 5'b00010},
        {6'h24, 4'b0010, 2'b10, 5'b00001},
        {6'h01, 4'b0110, 2'b10, 5'b00011},
        {6'h0F, 4'b0000, 2'b10, 5'b00000},
        {6'h2D, 4'b0110, 2'b10, 5'b00011},
        {6'h3F, 4'b0010, 2'b01, 5'b00101},
        {6'h12, 4'b0000, 2'b10, 5'b00000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_vld = 1'b0;
    logic [5:0]  hdr_dtype = '0;
    logic [15:0] hdr_wc = '0;
    logic        hdr_ecc_dbl = 1'b0, hdr_ecc_fix = 1'b0, hdr_sot_err = 1'b0, hdr_sync_err = 1'b0;
    logic        rx_vld = 1'b0;
    logic [31:0] rx_data = '0;
    logic [2:0]  rx_nb = '0;
    logic        rx_eot = 1'b0;
    logic        crc_vld = 1'b0, crc_bad = 1'b0;
    logic        out_vld, out_last, pkt_fwd, pkt_drop;
    logic [31:0] out_data;
    logic [2:0]  out_nb;
    logic        err_sync, err_ecc_dbl, err_dtype, err_ecc_fix, err_sot, err_crc, err_wc_trunc;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_gate uut (
        .clk(clk), .rst_n(rst_n),
        .hdr_vld(hdr_vld), .hdr_dtype(hdr_dtype), .hdr_wc(hdr_wc),
        .hdr_ecc_dbl(hdr_ecc_dbl), .hdr_ecc_fix(hdr_ecc_fix),
        .hdr_sot_err(hdr_sot_err), .hdr_sync_err(hdr_sync_err),
        .rx_vld(rx_vld), .rx_data(rx_data), .rx_nb(rx_nb), .rx_eot(rx_eot),
        .crc_vld(crc_vld), .crc_bad(crc_bad),
        .out_vld(out_vld), .out_data(out_data), .out_nb(out_nb), .out_last(out_last),
        .pkt_fwd(pkt_fwd), .pkt_drop(pkt_drop),
        .err_sync(err_sync), .err_ecc_dbl(err_ecc_dbl), .err_dtype(err_dtype),
        .err_ecc_fix(err_ecc_fix), .err_sot(err_sot), .err_crc(err_crc),
        .err_wc_trunc(err_wc_trunc)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clr();
        hdr_vld = 0; hdr_dtype = '0; hdr_wc = '0;
        hdr_ecc_dbl = 0; hdr_ecc_fix = 0; hdr_sot_err = 0; hdr_sync_err = 0;
        rx_vld = 0; rx_data = '0; rx_nb = '0; rx_eot = 0;
        crc_vld = 0; crc_bad = 0;
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    // flags packed as {fwd, drop, sync, dbl, dtype, fix, sot}
    function automatic logic [31:0] flags();
        return {25'd0, pkt_fwd, pkt_drop, err_sync, err_ecc_dbl, err_dtype, err_ecc_fix, err_sot};
    endfunction

    task automatic header(input logic [5:0] dt, input logic [15:0] wc, input logic eot);
        clr();
        hdr_vld = 1; hdr_dtype = dt; hdr_wc = wc; rx_eot = eot;
        cyc();
        clr();
    endtask

    task automatic beat(input logic [31:0] d, input logic [2:0] nb, input logic eot);
        clr();
        rx_vld = 1; rx_data = d; rx_nb = nb; rx_eot = eot;
        cyc();
        clr();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        clr();
        repeat (3) cyc();
        // R1 reset values while held
        chk("R1 flags in reset", flags(), 32'd0);
        chk("R1 out_vld in reset", {31'd0, out_vld}, 32'd0);
        rst_n = 1;
        cyc();
        chk("R1 flags after release", flags(), 32'd0);
        chk("R1 crc/trunc after release", {30'd0, err_crc, err_wc_trunc}, 32'd0);
        header(6'h2A, 16'd0, 1'b1);
        chk("R1 first header accepted", {31'd0, pkt_fwd}, 32'd1);
        crc_vld = 1; cyc(); clr();

        // table: header verdicts
        for (int i = 0; i < NV; i++) begin
            logic long_fwd;
            long_fwd = VEC[i][6] && (VEC[i][16:11] >= 6'h10);
            clr();
            hdr_vld = 1; hdr_dtype = VEC[i][16:11]; hdr_wc = 16'd8;
            hdr_ecc_dbl = VEC[i][10]; hdr_ecc_fix = VEC[i][9];
            hdr_sot_err = VEC[i][8]; hdr_sync_err = VEC[i][7];
            rx_eot = !long_fwd;
            cyc();
            clr();
            // R2 R3 R4 R5 R6 R10 verdict pulses
            chk($sformatf("R2/R3/R4/R5/R6/R10 verdict vec %0d", i), flags(), {25'd0, VEC[i][6:0]});
            if (long_fwd) begin
                rx_eot = 1; cyc(); clr();
                chk($sformatf("R9 flush vec %0d", i), {31'd0, err_wc_trunc}, 32'd1);
            end
        end

        // R8 count and mask, R7 CRC good and bad
        header(6'h2A, 16'd10, 1'b0);
        beat(32'h44332211, 3'd4, 1'b0);
        chk("R8 beat1 nb", {29'd0, out_nb}, 32'd4);
        chk("R12 beat1 data one cycle later", out_data, 32'h44332211);
        beat(32'h88776655, 3'd4, 1'b0);
        chk("R8 beat2 last", {31'd0, out_last}, 32'd0);
        beat(32'hDDCCBBAA, 3'd4, 1'b0);
        chk("R8 final nb", {29'd0, out_nb}, 32'd2);
        chk("R8 final masked data", out_data, 32'h0000BBAA);
        chk("R8 final last", {31'd0, out_last}, 32'd1);
        beat(32'h12345678, 3'd4, 1'b0);
        chk("R8 extra bytes not forwarded", {31'd0, out_vld}, 32'd0);
        clr(); crc_vld = 1; crc_bad = 1; cyc(); clr();
        chk("R7 bad crc pulse", {30'd0, err_crc, pkt_drop}, 32'd2);
        rx_eot = 1; cyc(); clr();

        header(6'h28, 16'd4, 1'b0);
        beat(32'hA1A2A3A4, 3'd4, 1'b0);
        clr(); crc_vld = 1; cyc(); clr();
        chk("R7 good crc no pulse", {31'd0, err_crc}, 32'd0);
        rx_eot = 1; cyc(); clr();

        // R9 truncation
        header(6'h2A, 16'd12, 1'b0);
        beat(32'h04030201, 3'd4, 1'b0);
        beat(32'h00070605, 3'd3, 1'b1);
        chk("R9 trunc nb", {29'd0, out_nb}, 32'd3);
        chk("R9 trunc last+flag", {30'd0, out_last, err_wc_trunc}, 32'd3);
        header(6'h2A, 16'd0, 1'b1);
        chk("R9 idle after trunc", {31'd0, pkt_fwd}, 32'd1);
        crc_vld = 1; cyc(); clr();

        // R9 exact completion with eot is not truncation
        header(6'h2A, 16'd8, 1'b0);
        beat(32'h11111111, 3'd4, 1'b0);
        beat(32'h22222222, 3'd4, 1'b1);
        chk("R9 exact end flags", {30'd0, out_last, err_wc_trunc}, 32'd2);
        clr(); crc_vld = 1; cyc(); clr();
        header(6'h24, 16'd0, 1'b1);
        chk("R9 back to idle after crc", {31'd0, pkt_fwd}, 32'd1);
        crc_vld = 1; cyc(); clr();

        // R11 header during body ignored
        header(6'h2A, 16'd8, 1'b0);
        clr();
        rx_vld = 1; rx_data = 32'h55555555; rx_nb = 3'd4;
        hdr_vld = 1; hdr_dtype = 6'h30; hdr_sync_err = 1;
        cyc(); clr();
        chk("R11 header ignored", flags(), 32'd0);
        chk("R11 beat still forwarded", {29'd0, out_nb}, 32'd4);
        beat(32'h66666666, 3'd4, 1'b1);
        clr(); crc_vld = 1; cyc(); clr();

        // R2 drain: dropped packet bytes not forwarded until eot
        clr(); hdr_vld = 1; hdr_dtype = 6'h2A; hdr_wc = 16'd8; hdr_ecc_dbl = 1; cyc(); clr();
        beat(32'h77777777, 3'd4, 1'b0);
        chk("R2 drained beat", {31'd0, out_vld}, 32'd0);
        beat(32'h88888888, 3'd4, 1'b1);
        chk("R2 drained eot beat", {31'd0, out_vld}, 32'd0);
        // R3 sync drop also drains
        clr(); hdr_vld = 1; hdr_dtype = 6'h2A; hdr_wc = 16'd8; hdr_sync_err = 1; cyc(); clr();
        beat(32'h99999999, 3'd4, 1'b0);
        chk("R3 drained beat", {31'd0, out_vld}, 32'd0);
        rx_eot = 1; cyc(); clr();

        // R10 short packet: no CRC wait
        header(6'h02, 16'h1234, 1'b1);
        clr(); crc_vld = 1; crc_bad = 1; cyc(); clr();
        chk("R10 crc ignored after short", {31'd0, err_crc}, 32'd0);
        header(6'h2A, 16'd4, 1'b0);
        chk("R10 idle after short", {31'd0, pkt_fwd}, 32'd1);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule